// File: doc/BRIEF.md
# Selectable G.711 companding converter

This block translates between signed linear samples and 8-bit companded codes under either of the two ITU-T G.711 laws, mu-law or A-law. It has two independent paths. The encode path takes a 14-bit two's-complement sample and returns a code. The decode path takes a code and returns a 14-bit two's-complement value. Each path accepts a request whenever its input valid is high and presents the result, with its own valid, exactly one clock later.

A single select input picks the law. The select is captured with every request, so the two paths may serve different laws on successive cycles. The block also drives a registered idle (silence) code for the currently selected law, which a framer can send when no speech is available. In every code the most significant bit is the sign bit, and it is the first bit a serialiser would shift out.

Top module: `g711_codec`

## Requirements
- R1: `law_sel` = 0 selects mu-law and `law_sel` = 1 selects A-law. The value is sampled together with each encode or decode request.
- R2: Mu-law encode works as follows. Take the magnitude |s|, limit it to 8158 and add 33 to get b. The segment is the smallest k in 0..7 with b < 64·2^k. The mantissa is b/2^(k+1) − 16, using integer division. With u = 16·k + mantissa, the code is 255 − u for s ≥ 0 and 127 − u for s < 0.
- R3: A-law encode works as follows. Let x = floor(s/2), which is the 13-bit linear value. Let m = x for x ≥ 0 and m = −x−1 for x < 0. If m < 32, then the segment is 0 and the mantissa is m/2. Otherwise the segment k is the smallest k ≥ 1 with m < 32·2^k, and the mantissa is m/2^k − 16. The code is (sign ? 0 : 128) | ((16·k + mantissa) XOR 8'h55), which inverts the even bits.
- R4: Out-of-range magnitudes saturate to the full-scale code of the same sign. For mu-law, every s ≥ 8158 gives 8'h80 and s = −8192 gives 8'h00. For A-law, s = 8191 gives 8'hAA and s = −8192 gives 8'h2A. Zero input gives 8'hFF in mu-law and 8'hD5 in A-law. In A-law, s = −1 gives 8'h55.
- R5: Bit 7 of every encoded code is 1 for a non-negative sample and 0 for a negative sample, under both laws.
- R6: `enc_valid_o` is `enc_valid_i` delayed by one clock. `enc_code_o` changes only in the cycle after an accepted request and holds its value otherwise.
- R7: Mu-law decode works as follows. Let c = 255 − code, k = c[6:4] and n = c[3:0]. Let t = (2n+33)·2^k − 33. The output is +t when code[7] = 1 and −t when code[7] = 0, so both 8'hFF and 8'h7F decode to 0.
- R8: A-law decode works as follows. Let a = code XOR 8'h55, k = a[6:4] and n = a[3:0]. The magnitude is 4n+2 when k = 0 and (2n+33)·2^k when k > 0, expressed in 14-bit units. The value is positive when a[7] = 1 and negative otherwise.
- R9: `dec_valid_o` is `dec_valid_i` delayed by one clock. `dec_sample_o` changes only in the cycle after an accepted request.
- R10: `idle_code_o` equals 8'hFF one clock after `law_sel` is 0, and 8'hD5 one clock after `law_sel` is 1.
- R11: While `rst` is high at a clock edge, both output valids clear and `idle_code_o` becomes 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| law_sel | input | 1 | 0 = mu-law, 1 = A-law |
| enc_valid_i | input | 1 | Encode request |
| enc_sample_i | input | 14 | Linear sample to encode, two's complement |
| enc_valid_o | output | 1 | Encode result valid |
| enc_code_o | output | 8 | Companded code |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | 8 | Code to decode |
| dec_valid_o | output | 1 | Decode result valid |
| dec_sample_o | output | 14 | Decoded linear value, two's complement |
| idle_code_o | output | 8 | Idle code for the selected law |

## Verification
The assertions check the following properties on every cycle:
- both valids follow their requests with one cycle of delay;
- the encoded sign bit tracks the sign of the sample;
- positive codes never decode to a negative value, and negative A-law codes always decode to a negative value;
- mu-law saturation at the positive limit holds;
- the idle code follows the select;
- results hold between requests.

The exact segment and mantissa arithmetic of both laws cannot be expressed as a simple property. Only the bench shows it, by sweeping every 14-bit sample and every 8-bit code under both laws against independently computed values, together with the reset values and the named boundary codes.

// File: rtl/g711_pkg.sv
package g711_pkg;

  localparam logic [7:0] IDLE_MU = 8'hFF;
  localparam logic [7:0] IDLE_A  = 8'hD5;
  localparam logic [6:0] A_EVEN_INV = 7'h55;

  // segment of a biased mu-law magnitude: bits 6..12 map to segments 1..7
  function automatic logic [2:0] mu_seg(input logic [12:0] b);
    logic [2:0] s;
    s = 3'd0;
    for (int i = 0; i < 7; i++) begin
      if (b[6+i]) s = 3'(i + 1);
    end
    return s;
  endfunction

  // segment of an A-law magnitude: bits 5..11 map to segments 1..7
  function automatic logic [2:0] a_seg(input logic [11:0] m);
    logic [2:0] s;
    s = 3'd0;
    for (int i = 0; i < 7; i++) begin
      if (m[5+i]) s = 3'(i + 1);
    end
    return s;
  endfunction

endpackage

// File: rtl/g711_mu_enc.sv
module g711_mu_enc #(
  parameter int LIN_W = 14
) (
  input  logic [LIN_W-1:0] sample,
  output logic [7:0]       code
);
  import g711_pkg::*;

  localparam logic [LIN_W-1:0] CLIP = LIN_W'(2**(LIN_W-1) - 34);
  localparam logic [LIN_W-1:0] BIAS = LIN_W'(33);

  logic             neg;
  logic [LIN_W-1:0] mag;
  logic [LIN_W-1:0] lim;
  logic [LIN_W-1:0] biased;
  logic [2:0]       seg;
  logic [LIN_W-1:0] shifted;
  logic [6:0]       uval;

  always_comb begin
    neg     = sample[LIN_W-1];
    mag     = neg ? (~sample + LIN_W'(1)) : sample;
    lim     = (mag > CLIP) ? CLIP : mag;
    biased  = lim + BIAS;
    seg     = mu_seg(biased[12:0]);
    shifted = biased >> ({1'b0, seg} + 4'd1);
    uval    = {seg, shifted[3:0]};
    code    = {~neg, ~uval};
  end

endmodule

// File: rtl/g711_a_enc.sv
module g711_a_enc #(
  parameter int LIN_W = 14
) (
  input  logic [LIN_W-1:0] sample,
  output logic [7:0]       code
);
  import g711_pkg::*;

  logic [LIN_W-2:0] x;
  logic             neg;
  logic [LIN_W-2:0] m;
  logic [2:0]       seg;
  logic [LIN_W-2:0] shifted;
  logic [3:0]       mant;

  always_comb begin
    x       = sample[LIN_W-1:1];
    neg     = x[LIN_W-2];
    m       = neg ? ~x : x;
    seg     = a_seg(m[11:0]);
    shifted = m >> seg;
    mant    = (seg == 3'd0) ? m[4:1] : shifted[3:0];
    code    = {~neg, {seg, mant} ^ A_EVEN_INV};
  end

endmodule

// File: rtl/g711_mu_dec.sv
module g711_mu_dec #(
  parameter int LIN_W = 14
) (
  input  logic [7:0]       code,
  output logic [LIN_W-1:0] sample
);

  logic [7:0]       c;
  logic [LIN_W-1:0] t;
  logic [LIN_W-1:0] mag;

  always_comb begin
    c      = ~code;
    t      = (LIN_W'({c[3:0], 1'b1}) + LIN_W'(32)) << c[6:4];
    mag    = t - LIN_W'(33);
    sample = code[7] ? mag : (~mag + LIN_W'(1));
  end

endmodule

// File: rtl/g711_a_dec.sv
module g711_a_dec #(
  parameter int LIN_W = 14
) (
  input  logic [7:0]       code,
  output logic [LIN_W-1:0] sample
);
  import g711_pkg::*;

  logic [7:0]       a;
  logic [LIN_W-1:0] mag;

  always_comb begin
    a = code ^ {1'b0, A_EVEN_INV};
    if (a[6:4] == 3'd0) mag = LIN_W'({a[3:0], 2'b10});
    else                mag = (LIN_W'({a[3:0], 1'b1}) + LIN_W'(32)) << a[6:4];
    sample = a[7] ? mag : (~mag + LIN_W'(1));
  end

endmodule

// File: rtl/g711_codec.sv
module g711_codec #(
  parameter int LIN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             law_sel,
  input  logic             enc_valid_i,
  input  logic [LIN_W-1:0] enc_sample_i,
  output logic             enc_valid_o,
  output logic [7:0]       enc_code_o,
  input  logic             dec_valid_i,
  input  logic [7:0]       dec_code_i,
  output logic             dec_valid_o,
  output logic [LIN_W-1:0] dec_sample_o,
  output logic [7:0]       idle_code_o
);
  import g711_pkg::*;

  logic [7:0]       mu_code, a_code;
  logic [LIN_W-1:0] mu_lin, a_lin;

  g711_mu_enc #(.LIN_W(LIN_W)) u_mu_enc (.sample(enc_sample_i), .code(mu_code));
  g711_a_enc  #(.LIN_W(LIN_W)) u_a_enc  (.sample(enc_sample_i), .code(a_code));
  g711_mu_dec #(.LIN_W(LIN_W)) u_mu_dec (.code(dec_code_i), .sample(mu_lin));
  g711_a_dec  #(.LIN_W(LIN_W)) u_a_dec  (.code(dec_code_i), .sample(a_lin));

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_o  <= 1'b0;
      dec_valid_o  <= 1'b0;
      enc_code_o   <= IDLE_MU;
      dec_sample_o <= '0;
      idle_code_o  <= IDLE_MU;
    end else begin
      enc_valid_o <= enc_valid_i;
      dec_valid_o <= dec_valid_i;
      idle_code_o <= law_sel ? IDLE_A : IDLE_MU;
      if (enc_valid_i) enc_code_o   <= law_sel ? a_code : mu_code;
      if (dec_valid_i) dec_sample_o <= law_sel ? a_lin : mu_lin;
    end
  end

endmodule

// File: rtl/g711_codec_chk.sv
module g711_codec_chk #(
  parameter int LIN_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             law_sel,
  input logic             enc_valid_i,
  input logic [LIN_W-1:0] enc_sample_i,
  input logic             enc_valid_o,
  input logic [7:0]       enc_code_o,
  input logic             dec_valid_i,
  input logic [7:0]       dec_code_i,
  input logic             dec_valid_o,
  input logic [LIN_W-1:0] dec_sample_o,
  input logic [7:0]       idle_code_o
);

  localparam int MU_SAT = 2**(LIN_W-1) - 34;

  p_enc_lat_r6: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o);
  p_enc_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_i |=> !enc_valid_o && $stable(enc_code_o));
  p_dec_lat_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);
  p_dec_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o && $stable(dec_sample_o));
  p_sign_r5: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_code_o[7] == !$past(enc_sample_i[LIN_W-1]));
  p_mu_sat_r4: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i && !law_sel && !enc_sample_i[LIN_W-1] &&
    (int'(enc_sample_i) >= MU_SAT) |=> enc_code_o == 8'h80);
  p_pos_dec_r7: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i && dec_code_i[7] |=> !dec_sample_o[LIN_W-1]);
  p_a_neg_dec_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i && law_sel && !dec_code_i[7] |=> dec_sample_o[LIN_W-1]);
  p_idle_a_r10: assert property (@(posedge clk) disable iff (rst)
    law_sel |=> idle_code_o == 8'hD5);
  p_idle_mu_r10: assert property (@(posedge clk) disable iff (rst)
    !law_sel |=> idle_code_o == 8'hFF);

endmodule

bind g711_codec g711_codec_chk #(.LIN_W(LIN_W)) i_chk (
  .clk(clk), .rst(rst), .law_sel(law_sel),
  .enc_valid_i(enc_valid_i), .enc_sample_i(enc_sample_i),
  .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
  .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
  .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o),
  .idle_code_o(idle_code_o)
);

// File: tb/test_g711_codec.sv
module test_g711_codec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        law_sel = 1'b0;
  logic        enc_valid_i = 1'b0;
  logic [13:0] enc_sample_i = '0;
  logic        enc_valid_o;
  logic [7:0]  enc_code_o;
  logic        dec_valid_i = 1'b0;
  logic [7:0]  dec_code_i = '0;
  logic        dec_valid_o;
  logic [13:0] dec_sample_o;
  logic [7:0]  idle_code_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  g711_codec #(.LIN_W(14)) i_g711_codec (
    .clk(clk), .rst(rst), .law_sel(law_sel),
    .enc_valid_i(enc_valid_i), .enc_sample_i(enc_sample_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o),
    .idle_code_o(idle_code_o)
  );

  function automatic int ref_mu_enc(int s);
    int mag, b, k, mant;
    mag = (s < 0) ? -s : s;
    if (mag > 8158) mag = 8158;
    b = mag + 33;
    k = 0;
    while (b >= (64 << k)) k++;
    mant = b / (2 << k) - 16;
    return (s < 0) ? 127 - (16*k + mant) : 255 - (16*k + mant);
  endfunction

  function automatic int ref_a_enc(int s);
    int x, m, k, mant;
    x = s >>> 1;
    m = (x < 0) ? -x - 1 : x;
    if (m < 32) begin
      k = 0; mant = m / 2;
    end else begin
      k = 1;
      while (m >= (32 << k)) k++;
      mant = m / (1 << k) - 16;
    end
    return ((x < 0) ? 0 : 128) | ((16*k + mant) ^ 85);
  endfunction

  function automatic int ref_mu_dec(int code);
    int c, t;
    c = 255 - code;
    t = ((2*(c & 15) + 33) << ((c >> 4) & 7)) - 33;
    return (code >= 128) ? t : -t;
  endfunction

  function automatic int ref_a_dec(int code);
    int a, k, n, mag;
    a = code ^ 85;
    k = (a >> 4) & 7;
    n = a & 15;
    mag = (k == 0) ? 4*n + 2 : (2*n + 33) << k;
    return (a >= 128) ? mag : -mag;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enc_one(bit law, int s, output int code);
    @(negedge clk);
    law_sel = law; enc_valid_i = 1'b1; enc_sample_i = 14'(s);
    @(negedge clk);
    enc_valid_i = 1'b0;
    code = int'(enc_code_o);
  endtask

  task automatic dec_one(bit law, int c, output int val);
    @(negedge clk);
    law_sel = law; dec_valid_i = 1'b1; dec_code_i = 8'(c);
    @(negedge clk);
    dec_valid_i = 1'b0;
    val = int'($signed(dec_sample_o));
  endtask

  initial begin
    int code, val, held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 enc_valid reset", int'(enc_valid_o), 0);
    check("R11 dec_valid reset", int'(dec_valid_o), 0);
    check("R11 idle reset", int'(idle_code_o), 255);
    rst = 1'b0;

    // R10: idle code follows the select one cycle later
    @(negedge clk); law_sel = 1'b1;
    @(negedge clk); check("R10 idle A-law", int'(idle_code_o), 8'hD5);
    law_sel = 1'b0;
    @(negedge clk); check("R10 idle mu-law", int'(idle_code_o), 8'hFF);

    // R4: named boundary codes
    enc_one(0, 8191, code);  check("R4 mu +sat", code, 8'h80);
    enc_one(0, 8158, code);  check("R4 mu 8158", code, 8'h80);
    enc_one(0, -8192, code); check("R4 mu -sat", code, 8'h00);
    enc_one(0, 0, code);     check("R4 mu zero", code, 8'hFF);
    enc_one(1, 8191, code);  check("R4 A +sat", code, 8'hAA);
    enc_one(1, -8192, code); check("R4 A -sat", code, 8'h2A);
    enc_one(1, 0, code);     check("R4 A zero", code, 8'hD5);
    enc_one(1, -1, code);    check("R4 A minus one", code, 8'h55);

    // R6: valid follows request, code holds without request
    @(negedge clk);
    law_sel = 1'b0; enc_valid_i = 1'b1; enc_sample_i = 14'(1000);
    @(negedge clk);
    check("R6 enc_valid one cycle", int'(enc_valid_o), 1);
    held = int'(enc_code_o);
    enc_valid_i = 1'b0; enc_sample_i = 14'(-5000); law_sel = 1'b1;
    @(negedge clk);
    check("R6 enc_valid drops", int'(enc_valid_o), 0);
    check("R6 code held", int'(enc_code_o), held);

    // R9: decode valid timing and hold
    @(negedge clk);
    law_sel = 1'b0; dec_valid_i = 1'b1; dec_code_i = 8'h20;
    @(negedge clk);
    check("R9 dec_valid one cycle", int'(dec_valid_o), 1);
    held = int'($signed(dec_sample_o));
    dec_valid_i = 1'b0; dec_code_i = 8'hA0;
    @(negedge clk);
    check("R9 dec_valid drops", int'(dec_valid_o), 0);
    check("R9 sample held", int'($signed(dec_sample_o)), held);

    // R7: both mu-law zero codes
    dec_one(0, 8'hFF, val); check("R7 mu +0", val, 0);
    dec_one(0, 8'h7F, val); check("R7 mu -0", val, 0);

    // R1 R2 R5: exhaustive mu-law encode
    for (int s = -8192; s < 8192; s++) begin
      enc_one(0, s, code);
      check("R1 R2 R5 mu encode", code, ref_mu_enc(s));
    end
    // R1 R3 R5: exhaustive A-law encode
    for (int s = -8192; s < 8192; s++) begin
      enc_one(1, s, code);
      check("R1 R3 R5 A encode", code, ref_a_enc(s));
    end
    // R7 R8: exhaustive decode under both laws
    for (int c = 0; c < 256; c++) begin
      dec_one(0, c, val);
      check("R1 R7 mu decode", val, ref_mu_dec(c));
      dec_one(1, c, val);
      check("R1 R8 A decode", val, ref_a_dec(c));
    end

    // R11: reset mid-run clears valids
    @(negedge clk);
    enc_valid_i = 1'b1; dec_valid_i = 1'b1; law_sel = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R11 enc_valid in reset", int'(enc_valid_o), 0);
    check("R11 dec_valid in reset", int'(dec_valid_o), 0);
    check("R11 idle in reset", int'(idle_code_o), 255);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0; rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule